// File: doc/BRIEF.md
# Per-Bit Interrupt Router with Independent Acknowledge

This block takes 32 level-sampled interrupt sources and routes the low 10 of them to 10 separate output lines, one line per source bit. An accumulating enable register decides which sources can raise anything. The same register also acts as a per-bit mask switch while service routines run. A 32-bit status register tells software which lines have fired. A source that fires while its status bit is still set, or while its bit is masked, is remembered in a hidden pending bit. It is re-issued when software acknowledges that one bit. Each bit is acknowledged, re-raised and lowered on its own, so a slow handler on one line never delays another line.

A source counts as firing in every clock cycle in which its input is high. Register writes are single-cycle strobes with their data. Both register values can be read at all times on the read-back outputs. Every output is a registered level that changes on the clock edge that samples the causing write or source.

Each output bit is controlled by its own four-state machine. The state holds the pair {pending, status}:
- LS_IDLE: nothing is recorded.
- LS_RAISED: the status bit is set.
- LS_HELD: the pending bit is set and the status bit is clear.
- LS_RAISED_HELD: both bits are set.

The transitions are:
- A firing source moves IDLE to RAISED, or to HELD when the bit is masked.
- A firing source moves RAISED to RAISED_HELD, and moves HELD to RAISED_HELD when the bit is unmasked.
- An acknowledge of the bit moves RAISED to IDLE.
- An acknowledge of the bit moves HELD and RAISED_HELD to RAISED (re-issue).
- A clear-all write moves RAISED to IDLE and RAISED_HELD to HELD.

An enable write is sorted into one of four kinds:
- EW_ZERO_IDLE: zero is written while nothing is enabled.
- EW_GROW: the write adds new enable bits.
- EW_UNMASK: no new bits are added, and some changed bit is 1 in the new value.
- EW_MASK: every other write.

Top module: `intc_bit_router`

## Requirements
- R1: After reset all outputs are low, status reads 0, enable reads 0, and all mask and pending bits are clear.
- R2: A source bit i < 10 that is high while enabled, unmasked and with status bit i clear sets status bit i and raises output i on that clock edge. Other status bits are left as they are.
- R3: A high source bit whose enable bit is clear changes neither the outputs nor the status register.
- R4: A high enabled source bit i whose mask bit or status bit is set sets pending bit i and leaves output i and status unchanged. Other bits keep operating independently.
- R5: A status write of 0x00000000 is ignored.
- R6: Any other status write (except all ones) clears the written status bits. For each written bit i < 10 whose pending bit is set, status bit i is set again, pending bit i is cleared and output i is held high. For each written bit i whose pending bit is clear, output i goes low.
- R7: A status write of 0xFFFFFFFF clears every status bit and leaves the outputs and pending bits untouched.
- R8: An enable write is treated as follows:
  - If it adds bits not yet enabled, it ORs them into the accumulated enable.
  - If it writes 0 while nothing is enabled, it changes only the read-back.
  - In all cases the enable read-back shows the last written value.
- R9: An enable write that adds no new bits computes change = previous written value XOR new value. If any bit of change is 1 in the new value, the mask bits in change are cleared. Otherwise the mask bits in change are set.
- R10: Source bits 10 to 31 can be enabled but never set status, pending or any output. Status bits 10 to 31 always read 0.
- R11: In a cycle with writes and sources together, both register writes take effect first. The sources are then judged against the status and pending bits after the status write, using the enable and mask values from before the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 32 | Source levels; a high bit fires that source in this cycle |
| en_we_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | 32 | Enable register write data |
| st_we_i | input | 1 | Status register write strobe |
| st_wdata_i | input | 32 | Status register write data (1 = acknowledge that bit) |
| en_rd_o | output | 32 | Enable register read-back (last written value) |
| st_rd_o | output | 32 | Status register read-back |
| irq_o | output | 10 | Per-bit output interrupt levels |

## Verification
The assertions assume that the write strobes and sources are known, 2-state values in every cycle after reset. They also assume that a status write of all ones is told apart from a per-bit acknowledge only by its data value. The stimulus keeps to this by driving every input from reset onward. It keeps the sources sparse so that masking, pending and re-issue all occur. It deliberately mixes zero, all-ones, single-bit and random status writes with sources in the same cycle, so that the ordering rule is exercised.

// File: rtl/intc_bit_router_pkg.sv
package intc_bit_router_pkg;

    // bit 0 = status, bit 1 = pending
    typedef enum logic [1:0] {
        LS_IDLE        = 2'b00,
        LS_RAISED      = 2'b01,
        LS_HELD        = 2'b10,
        LS_RAISED_HELD = 2'b11
    } line_state_e;

    typedef enum logic [1:0] {
        EW_ZERO_IDLE = 2'd0,
        EW_GROW      = 2'd1,
        EW_UNMASK    = 2'd2,
        EW_MASK      = 2'd3
    } en_write_e;

endpackage

// File: rtl/irq_en_ctl.sv
module irq_en_ctl
    import intc_bit_router_pkg::*;
#(
    parameter int NSRC = 32,
    parameter int NOUT = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we_i,
    input  logic [NSRC-1:0] wdata_i,
    output logic [NSRC-1:0] en_acc_o,
    output logic [NSRC-1:0] en_rd_o,
    output logic [NOUT-1:0] mask_o
);

    logic [NSRC-1:0] acc_q, wr_q, grown, change;
    logic [NOUT-1:0] mask_q;
    en_write_e       kind;

    always_comb begin
        grown  = acc_q | wdata_i;
        change = wr_q ^ wdata_i;
        if (wdata_i == '0 && acc_q == '0)
            kind = EW_ZERO_IDLE;
        else if (grown != acc_q)
            kind = EW_GROW;
        else if ((change & wdata_i) != '0)
            kind = EW_UNMASK;
        else
            kind = EW_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            wr_q   <= '0;
            mask_q <= '0;
        end else if (we_i) begin
            wr_q <= wdata_i;
            unique case (kind)
                EW_ZERO_IDLE: ;
                EW_GROW:      acc_q  <= grown;
                EW_UNMASK:    mask_q <= mask_q & ~change[NOUT-1:0];
                EW_MASK:      mask_q <= mask_q | change[NOUT-1:0];
            endcase
        end
    end

    assign en_acc_o = acc_q;
    assign en_rd_o  = wr_q;
    assign mask_o   = mask_q;

endmodule

// File: rtl/irq_line_fsm.sv
module irq_line_fsm
    import intc_bit_router_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    input  logic masked_i,
    input  logic ack_i,
    input  logic ack_all_i,
    output logic status_o,
    output logic irq_o
);

    line_state_e state_q, mid_state, nxt_state;
    logic        irq_q, mid_irq, nxt_irq;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LS_IDLE;
        else        state_q <= nxt_state;
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= nxt_irq;
    end

    always_comb begin
        mid_state = state_q;
        mid_irq   = irq_q;
        if (ack_i) begin
            unique case (state_q)
                LS_IDLE: begin
                    if (!ack_all_i) mid_irq = 1'b0;
                end
                LS_RAISED: begin
                    mid_state = LS_IDLE;
                    if (!ack_all_i) mid_irq = 1'b0;
                end
                LS_HELD, LS_RAISED_HELD: begin
                    if (ack_all_i) begin
                        mid_state = LS_HELD;
                    end else begin
                        mid_state = LS_RAISED;
                        mid_irq   = 1'b1;
                    end
                end
            endcase
        end

        nxt_state = mid_state;
        nxt_irq   = mid_irq;
        if (fire_i) begin
            unique case (mid_state)
                LS_IDLE: begin
                    if (masked_i) begin
                        nxt_state = LS_HELD;
                    end else begin
                        nxt_state = LS_RAISED;
                        nxt_irq   = 1'b1;
                    end
                end
                LS_RAISED: nxt_state = LS_RAISED_HELD;
                LS_HELD: begin
                    if (!masked_i) begin
                        nxt_state = LS_RAISED_HELD;
                        nxt_irq   = 1'b1;
                    end
                end
                LS_RAISED_HELD: nxt_state = LS_RAISED_HELD;
            endcase
        end
    end

    assign status_o = state_q[0];
    assign irq_o    = irq_q;

endmodule

// File: rtl/intc_bit_router.sv
module intc_bit_router #(
    parameter int NSRC = 32,
    parameter int NOUT = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_i,
    input  logic            en_we_i,
    input  logic [NSRC-1:0] en_wdata_i,
    input  logic            st_we_i,
    input  logic [NSRC-1:0] st_wdata_i,
    output logic [NSRC-1:0] en_rd_o,
    output logic [NSRC-1:0] st_rd_o,
    output logic [NOUT-1:0] irq_o
);

    localparam logic [NSRC-1:0] ALL_ONES = {NSRC{1'b1}};

    logic [NSRC-1:0] en_acc;
    logic [NOUT-1:0] mask;
    logic [NOUT-1:0] status_bits;
    logic [NOUT-1:0] fire;
    logic            wr_live;
    logic            wr_all;

    irq_en_ctl #(.NSRC(NSRC), .NOUT(NOUT)) u_en (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (en_we_i),
        .wdata_i  (en_wdata_i),
        .en_acc_o (en_acc),
        .en_rd_o  (en_rd_o),
        .mask_o   (mask)
    );

    assign wr_live = st_we_i && (st_wdata_i != '0);
    assign wr_all  = (st_wdata_i == ALL_ONES);
    assign fire    = src_i[NOUT-1:0] & en_acc[NOUT-1:0];

    for (genvar g = 0; g < NOUT; g++) begin : g_line
        irq_line_fsm u_line (
            .clk       (clk),
            .rst_n     (rst_n),
            .fire_i    (fire[g]),
            .masked_i  (mask[g]),
            .ack_i     (wr_live && st_wdata_i[g]),
            .ack_all_i (wr_all),
            .status_o  (status_bits[g]),
            .irq_o     (irq_o[g])
        );
    end

    assign st_rd_o = NSRC'(status_bits);

endmodule

// File: rtl/intc_bit_router_chk.sv
module intc_bit_router_chk #(
    parameter int NSRC = 32,
    parameter int NOUT = 10
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] src_i,
    input logic            st_we_i,
    input logic [NSRC-1:0] st_wdata_i,
    input logic [NSRC-1:0] en_acc,
    input logic [NSRC-1:0] st_rd_o,
    input logic [NOUT-1:0] irq_o
);

    logic            no_fire;
    logic            all_ones;
    logic [NOUT-1:0] ack_lo;

    assign no_fire  = ~|(src_i[NOUT-1:0] & en_acc[NOUT-1:0]);
    assign all_ones = &st_wdata_i;
    assign ack_lo   = (st_we_i && !all_ones) ? st_wdata_i[NOUT-1:0] : '0;

    a_r3_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_we_i && no_fire) |=> ($stable(irq_o) && $stable(st_rd_o)));

    a_r5_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
        (st_we_i && st_wdata_i == '0 && no_fire) |=> ($stable(irq_o) && $stable(st_rd_o)));

    a_r7_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        (st_we_i && all_ones && no_fire) |=> (st_rd_o == '0 && $stable(irq_o)));

    for (genvar g = 0; g < NOUT; g++) begin : g_bit
        a_r2_rise_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_o[g]) |-> st_rd_o[g]);

        a_r6_fall_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(irq_o[g]) |-> $past(ack_lo[g]));
    end

endmodule

bind intc_bit_router intc_bit_router_chk #(.NSRC(NSRC), .NOUT(NOUT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_i      (src_i),
    .st_we_i    (st_we_i),
    .st_wdata_i (st_wdata_i),
    .en_acc     (en_acc),
    .st_rd_o    (st_rd_o),
    .irq_o      (irq_o)
);

// File: tb/tb_intc_bit_router.sv
`timescale 1ns/1ps
module tb_intc_bit_router;

    localparam int NSRC = 32;
    localparam int NOUT = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src_i = '0;
    logic            en_we_i = 1'b0;
    logic [NSRC-1:0] en_wdata_i = '0;
    logic            st_we_i = 1'b0;
    logic [NSRC-1:0] st_wdata_i = '0;
    logic [NSRC-1:0] en_rd_o, st_rd_o;
    logic [NOUT-1:0] irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] m_en, m_enreg;
    logic [9:0]  m_mask, m_st, m_pd, m_out;

    always #2 clk = ~clk;

    intc_bit_router #(.NSRC(NSRC), .NOUT(NOUT)) dut (
        .clk(clk), .rst_n(rst_n), .src_i(src_i),
        .en_we_i(en_we_i), .en_wdata_i(en_wdata_i),
        .st_we_i(st_we_i), .st_wdata_i(st_wdata_i),
        .en_rd_o(en_rd_o), .st_rd_o(st_rd_o), .irq_o(irq_o)
    );

    task automatic model_reset();
        m_en = '0; m_enreg = '0; m_mask = '0; m_st = '0; m_pd = '0; m_out = '0;
    endtask

    // Expected behaviour per R2..R11
    task automatic model_step(input logic ew, input logic [31:0] ed,
                              input logic sw, input logic [31:0] sd,
                              input logic [31:0] s);
        logic [31:0] old_en;
        logic [9:0]  old_mask;
        logic [31:0] chg;
        old_en   = m_en;
        old_mask = m_mask;
        if (ew) begin
            if (ed == 0 && m_en == 0) begin
                m_enreg = ed;
            end else if ((m_en | ed) != m_en) begin
                m_en    = m_en | ed;
                m_enreg = ed;
            end else begin
                chg = m_enreg ^ ed;
                if ((chg & ed) != 0) m_mask = m_mask & ~chg[9:0];
                else                 m_mask = m_mask | chg[9:0];
                m_enreg = ed;
            end
        end
        if (sw && sd != 0) begin
            m_st = m_st & ~sd[9:0];
            if (sd != 32'hFFFF_FFFF) begin
                for (int i = 0; i < 10; i++) begin
                    if (sd[i]) begin
                        if (m_pd[i]) begin
                            m_st[i] = 1'b1; m_pd[i] = 1'b0; m_out[i] = 1'b1;
                        end else begin
                            m_out[i] = 1'b0;
                        end
                    end
                end
            end
        end
        for (int i = 0; i < 10; i++) begin
            if (s[i] && old_en[i]) begin
                if (old_mask[i] || m_st[i]) m_pd[i] = 1'b1;
                else begin m_st[i] = 1'b1; m_out[i] = 1'b1; end
            end
        end
    endtask

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check(tag, "irq", 32'(irq_o), 32'(m_out));
        check(tag, "status", st_rd_o, 32'(m_st));
        check(tag, "enable", en_rd_o, m_enreg);
    endtask

    task automatic cyc(input logic ew, input logic [31:0] ed,
                       input logic sw, input logic [31:0] sd,
                       input logic [31:0] s, input string tag);
        en_we_i = ew; en_wdata_i = ed; st_we_i = sw; st_wdata_i = sd; src_i = s;
        @(posedge clk);
        #1;
        en_we_i = 1'b0; en_wdata_i = '0; st_we_i = 1'b0; st_wdata_i = '0; src_i = '0;
        model_step(ew, ed, sw, sd, s);
        check_all(tag);
    endtask

    initial begin
        int unused;
        unused = $urandom(32'h5EED_1234);
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        check_all("R1");
        cyc(0, 0, 0, 0, 0, "R1");

        cyc(1, 32'h0010_0003, 0, 0, 0, "R8");            // enable bits 0,1,20
        cyc(0, 0, 0, 0, 32'h1, "R2");                    // raise line 0
        cyc(0, 0, 0, 0, 32'h4, "R3");                    // bit 2 not enabled
        cyc(0, 0, 0, 0, 32'h0010_0000, "R10");           // bit 20 enabled, no output
        cyc(0, 0, 0, 0, 32'h1, "R4");                    // status set -> pending
        cyc(0, 0, 1, 32'h0, 0, "R5");                    // zero write ignored
        cyc(0, 0, 1, 32'h1, 0, "R6");                    // re-issue from pending
        check("R6", "irq0 held", 32'(irq_o[0]), 32'h1);
        cyc(0, 0, 1, 32'h1, 0, "R6");                    // no pending -> low
        check("R6", "irq0 low", 32'(irq_o[0]), 32'h0);
        cyc(0, 0, 0, 0, 32'h2, "R2");                    // raise line 1
        cyc(0, 0, 1, 32'hFFFF_FFFF, 0, "R7");            // clear all, output kept
        check("R7", "irq1 kept", 32'(irq_o[1]), 32'h1);
        cyc(1, 32'h0010_0001, 0, 0, 0, "R9");            // mask bit 1
        cyc(0, 0, 0, 0, 32'h2, "R9");                    // masked -> pending
        check("R9", "status1 clear", st_rd_o, 32'h0);
        cyc(1, 32'h0010_0003, 0, 0, 0, "R9");            // unmask bit 1
        cyc(0, 0, 1, 32'h2, 0, "R6");                    // pending re-issued
        check("R6", "status1 reissued", st_rd_o, 32'h2);
        cyc(0, 0, 1, 32'h2, 0, "R6");
        cyc(0, 0, 0, 0, 32'h3, "R4");                    // raise both lines
        cyc(0, 0, 1, 32'h1, 0, "R4");                    // ack 0 only
        check("R4", "line1 independent", 32'(irq_o), 32'h2);
        cyc(0, 0, 0, 0, 32'h1, "R2");
        cyc(0, 0, 1, 32'h1, 32'h1, "R11");               // ack and fire together
        check("R11", "status0 after ack+fire", st_rd_o, 32'h3);
        cyc(1, 32'h0000_03FF, 0, 0, 0, "R8");
        cyc(1, 32'h0, 0, 0, 0, "R9");                    // masks all written bits

        for (int n = 0; n < 4000; n++) begin
            logic        ew, sw;
            logic [31:0] ed, sd, s;
            ew = ($urandom % 8) == 0;
            case ($urandom % 4)
                0: ed = 32'h0;
                1: ed = $urandom & 32'h3FF;
                2: ed = m_enreg ^ (32'h1 << ($urandom % 10));
                default: ed = $urandom;
            endcase
            sw = ($urandom % 5) == 0;
            case ($urandom % 4)
                0: sd = 32'h0;
                1: sd = 32'hFFFF_FFFF;
                2: sd = 32'h1 << ($urandom % 10);
                default: sd = $urandom & 32'h3FF;
            endcase
            s = $urandom & $urandom & $urandom;
            cyc(ew, ed, sw, sd, s, "R11");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #600000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule